// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the master side of a short serial exchange with a small two-channel analog-to-digital converter. It drives four lines: an active-low chip select, a serial clock, a data line towards the converter and a data line from it. A single pulse on `start_i` starts one conversion exchange. The channel and mode selection, the wire mode and the clock divider setting are sampled when the request is accepted. The controller lowers chip select and toggles the serial clock at a rate set by the divider. In four-wire mode it sends a five-bit command: a start bit, a single-ended/differential select, an odd/sign select and two padding bits. It then skips two null bit times and shifts in an 8-bit result, most significant bit first. After that it returns the clock low, raises chip select and reports the byte with a one-cycle done strobe.

In three-wire mode no command goes out and the data line to the converter stays low. The first serial clock only wakes the converter's output. Two null bit times follow, and then the result. Chip select then stays high for a guaranteed minimum time, and `busy_o` stays high until that time is over. Requests that arrive while busy are dropped.

The control is a four-state machine. ST_IDLE waits for a request and moves to ST_XFER when one is accepted. ST_XFER produces the serial clock, sends the command and captures the result. It moves to ST_TAIL on the rising clock edge that captures the last result bit. ST_TAIL waits one half period, drops the clock, raises chip select, strobes done and moves to ST_GAP. ST_GAP counts the chip-select high time and returns to ST_IDLE.

Top module: `adc_serial_host`

## Requirements
- R1: In reset and after reset `cs_n_o`=1, `sclk_o`=0, `din_o`=0, `busy_o`=0, `done_o`=0 and `result_o`=0.
- R2: When idle, `start_i`=1 lowers `cs_n_o` and raises `busy_o` on the next clock. `sclk_o` idles low, and each of its half periods lasts `div_i`+1 system clocks, using the value of `div_i` sampled at acceptance.
- R3: In four-wire mode (`three_wire_i`=0), `din_o` holds these values at the serial clock rising edges 1 to 5: 1, `single_ended_i`, `odd_sign_i`, 0, 0. After that it is 0. `din_o` changes only while `sclk_o` is low.
- R4: In four-wire mode, `dout_i` is ignored at rising edges 1 to 7. It is sampled at rising edges 8 to 15, and the first sample becomes bit 7 of the result.
- R5: In three-wire mode (`three_wire_i`=1), `din_o` stays 0 for the whole exchange. `dout_i` is ignored at rising edges 1 to 3 and sampled at rising edges 4 to 11, most significant bit first.
- R6: An exchange has exactly 15 rising edges in four-wire mode or 11 in three-wire mode. `sclk_o` falls one half period after the last one, and `cs_n_o` rises on that same clock. `sclk_o` is low whenever `cs_n_o` is high.
- R7: `done_o` is high for exactly one clock, the clock in which `cs_n_o` rises. `result_o` then carries the captured byte and keeps it until the next done.
- R8: After an exchange, `cs_n_o` stays high for at least CS_GAP system clocks. `busy_o` stays high until that time has passed, and chip select falls only when `busy_o` was low.
- R9: `start_i` pulses and changes to the mode, selection and divider inputs while `busy_o`=1 do not change the running exchange and do not queue a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one exchange (accepted only when idle) |
| three_wire_i | input | 1 | 1 = three-wire variant without command word |
| single_ended_i | input | 1 | Select bit: 1 single-ended, 0 differential |
| odd_sign_i | input | 1 | Odd/sign channel select bit |
| div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| dout_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle low |
| din_o | output | 1 | Serial command data to the converter |
| busy_o | output | 1 | Exchange or chip-select recovery in progress |
| done_o | output | 1 | One-cycle strobe marking a valid result |
| result_o | output | RES_W | Last captured conversion result |

## Verification
The bench models the converter. Its model drives ones on the null and wake-up bit times, so a controller that samples one position too early shows a corrupted top bit. A controller that sends an extra clock after the least significant bit shows up in the model's edge count. The model checks every command bit at the rising edge where the converter would latch it, so a swapped select bit or a mistimed data change is caught. The bench also pokes `start_i`, the mode and the select inputs in the middle of an exchange, and times the chip-select high gap. A controller that samples its inputs late, queues requests or shortens the recovery time therefore sends the wrong command or lowers chip select too early.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_TAIL,
        ST_GAP
    } host_state_t;

    // start bit + select + odd/sign + two padding bits
    localparam int CMD_BITS  = 5;
    localparam int NULL_BITS = 2;
endpackage

// File: rtl/adc_sclk_div.sv
`timescale 1ns/1ps
module adc_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    half_period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/adc_rx_shift.sv
`timescale 1ns/1ps
module adc_rx_shift #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [RES_W-1:0] data_o
);
    logic [RES_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clr_i) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= {sr_q[RES_W-2:0], bit_i};
        end
    end

    assign data_o = sr_q;
endmodule

// File: rtl/adc_serial_host.sv
`timescale 1ns/1ps
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int RES_W  = 8,
    parameter int CS_GAP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             three_wire_i,
    input  logic             single_ended_i,
    input  logic             odd_sign_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             dout_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             din_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int CNT_W = $clog2(CMD_BITS + NULL_BITS + RES_W + 1);
    localparam int GAP_W = $clog2(CS_GAP + 1);
    localparam int CFG_W = CMD_BITS - 1;
    localparam logic [CNT_W-1:0] LEAD_4W  = CNT_W'(CMD_BITS);
    localparam logic [CNT_W-1:0] LEAD_3W  = CNT_W'(1);
    localparam logic [CNT_W-1:0] NULL_CNT = CNT_W'(NULL_BITS);
    localparam logic [CNT_W-1:0] RES_CNT  = CNT_W'(RES_W);
    localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(CS_GAP - 1);

    host_state_t       state_q, state_d;
    logic              three_q;
    logic [DIV_W-1:0]  div_q;
    logic [CFG_W-1:0]  cfg_sr_q;
    logic [CNT_W-1:0]  rise_cnt_q;
    logic [GAP_W-1:0]  gap_cnt_q;
    logic [CNT_W-1:0]  lead_len, first_cap, last_rise, rise_nxt;
    logic              tick, accept, rise_ev, cap_en;
    logic [RES_W-1:0]  rx_data;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign lead_len  = three_q ? LEAD_3W : LEAD_4W;
    assign first_cap = lead_len + NULL_CNT + 1'b1;
    assign last_rise = lead_len + NULL_CNT + RES_CNT;
    assign rise_nxt  = rise_cnt_q + 1'b1;
    assign rise_ev   = (state_q == ST_XFER) && tick && !sclk_o;
    assign cap_en    = rise_ev && (rise_nxt >= first_cap);
    assign busy_o    = (state_q != ST_IDLE);

    adc_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   ((state_q == ST_XFER) || (state_q == ST_TAIL)),
        .div_i  (div_q),
        .tick_o (tick)
    );

    adc_rx_shift #(.RES_W(RES_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .shift_i (cap_en),
        .bit_i   (dout_i),
        .data_o  (rx_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_XFER;
            ST_XFER: if (rise_ev && rise_nxt == last_rise) state_d = ST_TAIL;
            ST_TAIL: if (tick) state_d = ST_GAP;
            ST_GAP:  if (gap_cnt_q == GAP_END) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o     <= 1'b1;
            sclk_o     <= 1'b0;
            din_o      <= 1'b0;
            done_o     <= 1'b0;
            result_o   <= '0;
            three_q    <= 1'b0;
            div_q      <= '0;
            cfg_sr_q   <= '0;
            rise_cnt_q <= '0;
            gap_cnt_q  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cs_n_o     <= 1'b0;
                        three_q    <= three_wire_i;
                        div_q      <= div_i;
                        rise_cnt_q <= '0;
                        din_o      <= !three_wire_i;
                        cfg_sr_q   <= three_wire_i ? '0
                                    : {single_ended_i, odd_sign_i, {(CFG_W-2){1'b0}}};
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        sclk_o <= !sclk_o;
                        if (!sclk_o) begin
                            rise_cnt_q <= rise_nxt;
                        end else begin
                            din_o    <= cfg_sr_q[CFG_W-1];
                            cfg_sr_q <= {cfg_sr_q[CFG_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        sclk_o    <= 1'b0;
                        cs_n_o    <= 1'b1;
                        din_o     <= 1'b0;
                        done_o    <= 1'b1;
                        result_o  <= rx_data;
                        gap_cnt_q <= '0;
                    end
                end
                ST_GAP: begin
                    gap_cnt_q <= gap_cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R6
    cs_high_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R3
    din_quiet_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(din_o));
    // R5
    three_wire_din_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (three_q && !cs_n_o) |-> !din_o);
    // R7
    done_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !$past(cs_n_o)));
    // R8
    cs_fall_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !$past(busy_o));
    // R6
    rise_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt_q <= last_rise);
endmodule

// File: tb/tb_adc_serial_host.sv
`timescale 1ns/1ps
module tb_adc_serial_host;
    localparam int CS_GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       three_wire_i = 1'b0;
    logic       single_ended_i = 1'b0;
    logic       odd_sign_i = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic       dout_i = 1'b0;
    logic       cs_n_o, sclk_o, din_o, busy_o, done_o;
    logic [7:0] result_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    // converter model state
    logic       m_tw, m_sgl, m_odd;
    logic [7:0] m_word;
    int         m_rise = 0, m_din_err = 0, m_t1 = 0, m_t2 = 0;

    // {three_wire, single_ended, odd_sign, div[7:0], word[7:0]}
    localparam logic [18:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b0, 8'd0, 8'hA5},
        {1'b0, 1'b0, 1'b1, 8'd1, 8'h3C},
        {1'b0, 1'b1, 1'b1, 8'd3, 8'hFF},
        {1'b1, 1'b1, 1'b0, 8'd0, 8'h81},
        {1'b1, 1'b0, 1'b1, 8'd2, 8'h00},
        {1'b0, 1'b0, 1'b0, 8'd2, 8'h6E}
    };

    adc_serial_host #(.DIV_W(8), .RES_W(8), .CS_GAP(CS_GAP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .three_wire_i(three_wire_i),
        .single_ended_i(single_ended_i), .odd_sign_i(odd_sign_i), .div_i(div_i),
        .dout_i(dout_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge cs_n_o) begin
        m_rise = 0;
        m_din_err = 0;
        dout_i = 1'b1;
    end

    always @(posedge sclk_o) begin
        int   lead;
        int   nxt;
        logic expd;
        if (!cs_n_o) begin
            m_rise++;
            if (m_rise == 1) m_t1 = cyc;
            if (m_rise == 2) m_t2 = cyc;
            lead = m_tw ? 1 : 5;
            if (m_tw) expd = 1'b0;
            else begin
                case (m_rise)
                    1:       expd = 1'b1;
                    2:       expd = m_sgl;
                    3:       expd = m_odd;
                    default: expd = 1'b0;
                endcase
            end
            if (din_o !== expd) m_din_err++;
            nxt = m_rise + 1;
            // ones on wake-up and null slots expose an early capture
            if (nxt <= lead + 2)       dout_i = 1'b1;
            else if (nxt <= lead + 10) dout_i = m_word[7 - (nxt - lead - 3)];
            else                       dout_i = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_ex(input logic tw, input logic sgl, input logic odd,
                          input logic [7:0] dv, input logic [7:0] wd, input bit poke);
        bit seen;
        int hi;
        m_tw = tw; m_sgl = sgl; m_odd = odd; m_word = wd;
        @(negedge clk);
        three_wire_i = tw; single_ended_i = sgl; odd_sign_i = odd; div_i = dv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !cs_n_o, "R2", "accept lowers cs/raises busy",
              {busy_o, cs_n_o}, 2);
        // R9: inputs move after acceptance
        three_wire_i = ~tw; single_ended_i = ~sgl; odd_sign_i = ~odd; div_i = dv + 8'd3;
        seen = 0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            start_i = (poke && (n == 10 || n == 11));
            if (done_o) begin
                seen = 1;
                break;
            end
        end
        start_i = 1'b0;
        check(seen, "R7", "done strobe seen", seen, 1);
        if (tw) check(result_o == wd, "R5", "three-wire result", result_o, wd);
        else    check(result_o == wd, "R4", "four-wire result", result_o, wd);
        check(m_rise == (tw ? 11 : 15), "R6", "rising edge count", m_rise, tw ? 11 : 15);
        if (tw) check(m_din_err == 0, "R5", "din held low", m_din_err, 0);
        else    check(m_din_err == 0, "R3", "command bits", m_din_err, 0);
        check(m_t2 - m_t1 == 2 * (dv + 1), "R2", "sclk period", m_t2 - m_t1, 2 * (dv + 1));
        check(cs_n_o && !sclk_o, "R6", "cs high sclk low at done", {cs_n_o, sclk_o}, 2);
        @(negedge clk);
        check(!done_o, "R7", "done one cycle", done_o, 0);
        hi = 2;
        while (busy_o && hi < 100) begin
            if (!cs_n_o) check(0, "R8", "cs low while recovering", cs_n_o, 1);
            @(negedge clk);
            hi++;
        end
        check(hi - 1 >= CS_GAP, "R8", "cs high cycles", hi - 1, CS_GAP);
        for (int k = 0; k < 12; k++) @(negedge clk);
        if (poke) check(cs_n_o && !busy_o, "R9", "request while busy not queued",
                        {cs_n_o, busy_o}, 2);
        check(result_o == wd, "R7", "result held", result_o, wd);
    endtask

    initial begin
        logic [18:0] v;
        repeat (3) @(negedge clk);
        check(cs_n_o && !sclk_o && !din_o && !busy_o && !done_o && result_o == 0,
              "R1", "reset state", {cs_n_o, sclk_o, din_o, busy_o, done_o}, 16);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n_o && !busy_o, "R1", "idle after reset", {cs_n_o, busy_o}, 2);

        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            run_ex(v[18], v[17], v[16], v[15:8], v[7:0], 1'b0);
        end

        // R9: start pulses and input changes mid-exchange
        run_ex(1'b0, 1'b1, 1'b1, 8'd1, 8'h5A, 1'b1);
        run_ex(1'b1, 1'b0, 1'b0, 8'd0, 8'hC3, 1'b1);

        // R1: reset in the middle of an exchange
        m_tw = 1'b0; m_sgl = 1'b0; m_odd = 1'b0; m_word = 8'h11;
        @(negedge clk);
        three_wire_i = 1'b0; div_i = 8'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n_o && !sclk_o && !busy_o && result_o == 0, "R1", "reset mid exchange",
              {cs_n_o, sclk_o, busy_o}, 4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule